// File: doc/BRIEF.md
# Wide-to-Narrow External Bus Access Splitter

This block sits on the controller side of an asynchronous external memory port. It takes a single-cycle internal request and breaks it into one or more accesses on a narrow external bus. Each request carries a byte address, a 32-bit write word, byte enables, a direction and a size of 8, 16 or 32 bits. A configuration input sets the external bus to 8 or 16 bits wide. The external address pins always hold the 32-bit word index. Only the two bank bits move between the accesses of one request, so they pick the halfword or byte inside that word. Read data from each access is merged into a 32-bit response.

A request is accepted only while `req_ready` is high. `req_ready` is high only in state IDLE. States: IDLE (wait for a request), SETUP (chip select low, strobes high), STROBE (read or write strobe low), HOLD (chip select low, strobes released), RESP (response valid for one cycle). Transitions: IDLE→SETUP on a legal request. IDLE→RESP on an out-of-region or misaligned request. SETUP→STROBE when the setup count expires. STROBE→HOLD when the strobe count expires. HOLD→SETUP when more accesses remain, with the bank bits stepped. HOLD→RESP after the last access. RESP→IDLE always.

Top module: `ext_bus_splitter`

## Requirements
- R1: A request is in range when byte address bits [31:25] equal 7'b0110001, which covers 0x6200_0000 to 0x63FF_FFFF. Any other address gives `rsp_err`=1, `rsp_rdata`=0 and no external access.
- R2: A request that is not aligned to its size is answered with `rsp_err`=1 and no external access. The size codes are 0=8-bit, 1=16-bit, 2=32-bit, and code 3 is illegal.
- R3: The number of external accesses is as follows. With a 16-bit bus (`cfg_asize`=1), a 32-bit request takes 2 accesses and an 8-bit or 16-bit request takes 1. With an 8-bit bus (`cfg_asize`=0), the counts are 4, 2 and 1 for 32-bit, 16-bit and 8-bit requests.
- R4: `ext_a` equals byte address bits [EXT_A_W+1:2]. It stays constant across all accesses of one request.
- R5: With a 16-bit bus, `ext_ba[1]` starts at address bit 1 and `ext_ba[0]` is 0. A 32-bit request accesses `ext_ba`=00 first and 10 second.
- R6: With an 8-bit bus, `ext_ba` starts at address bits [1:0] and rises by one on each further access. A 32-bit request therefore steps 00, 01, 10, 11.
- R7: Each access holds `ext_cs_n` low for SETUP_CYC+STROBE_CYC+HOLD_CYC cycles (default 1+2+1). The strobe (`ext_oe_n` for reads, `ext_we_n` for writes) is low only during the STROBE_CYC middle cycles. The one-cycle `rsp_valid` pulse follows the last hold cycle. After the accepting edge, a request with n accesses responds 4n cycles later (0 for errors).
- R8: On reads, each access's data is placed in the response lane chosen by `ext_ba`: halfword `ext_ba[1]` uses `ext_din[15:0]`, and byte `ext_ba` uses `ext_din[7:0]`. The first access of a 32-bit read fills the least significant bits. Lanes that are not read are 0.
- R9: On writes, `ext_dout` carries the write-data lane selected by `ext_ba`. With an 8-bit bus the byte sits in bits [7:0] and bits [15:8] are 0. `ext_be_n` carries the inverted byte enables of that lane. With an 8-bit bus, `ext_be_n[1]` is 1. On reads, the used lanes of `ext_be_n` are 0.
- R10: While a request is in progress, `req_ready` is low and `req_valid` has no effect. No extra external access or response results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_asize | input | 1 | External bus width: 0 = 8-bit, 1 = 16-bit |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 32 | Assembled read data |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_oe_n | output | 1 | Read strobe, active low |
| ext_we_n | output | 1 | Write strobe, active low |
| ext_a | output | EXT_A_W | Word-index address pins |
| ext_ba | output | 2 | Bank bits selecting halfword or byte |
| ext_be_n | output | 2 | Lane byte enables, active low |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |

## Verification
The bench drives each request on a falling edge. It then counts the rising edges after the accepting edge until `rsp_valid` is seen, sampling on falling edges. The expected count is 4n for n accesses and 0 for a rejected request. A passive monitor samples the external pins on every falling edge. It counts chip-select-low and strobe-low cycles, expecting 4n and 2n, and logs `ext_a`, `ext_ba`, `ext_dout` and `ext_be_n` on the first strobe cycle of each access, so address, bank order and lane are checked per access. Read data comes from an address-dependent model of the external device, and the response word is compared in the cycle `rsp_valid` is high.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RESP
    } ebs_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/ebs_decode.sv
module ebs_decode
    import ebs_pkg::*;
#(
    parameter int                    REGION_TAG_W = 7,
    parameter logic [REGION_TAG_W-1:0] REGION_TAG = 7'h31
) (
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    input  logic        wide,
    output logic        hit,
    output logic        bad_align,
    output logic [2:0]  n_acc,
    output logic [1:0]  ba_first
);
    always_comb begin
        hit = (addr[31 -: REGION_TAG_W] == REGION_TAG);
        unique case (size)
            SZ_BYTE: bad_align = 1'b0;
            SZ_HALF: bad_align = addr[0];
            SZ_WORD: bad_align = |addr[1:0];
            default: bad_align = 1'b1;
        endcase
        if (wide) begin
            n_acc    = (size == SZ_WORD) ? 3'd2 : 3'd1;
            ba_first = {addr[1], 1'b0};
        end else begin
            n_acc    = (size == SZ_WORD) ? 3'd4 : ((size == SZ_HALF) ? 3'd2 : 3'd1);
            ba_first = addr[1:0];
        end
    end
endmodule

// File: rtl/ebs_lane.sv
module ebs_lane (
    input  logic        wide,
    input  logic        write,
    input  logic [1:0]  ba,
    input  logic [31:0] wdata,
    input  logic [3:0]  be,
    input  logic [15:0] din,
    input  logic [31:0] rdata_in,
    output logic [15:0] dout,
    output logic [1:0]  be_n,
    output logic [31:0] rdata_out
);
    always_comb begin
        rdata_out = rdata_in;
        if (wide) begin
            dout = wdata[{ba[1], 4'b0000} +: 16];
            be_n = write ? ~be[{ba[1], 1'b0} +: 2] : 2'b00;
            rdata_out[{ba[1], 4'b0000} +: 16] = din;
        end else begin
            dout = {8'h00, wdata[{ba, 3'b000} +: 8]};
            be_n = {1'b1, write ? ~be[ba] : 1'b0};
            rdata_out[{ba, 3'b000} +: 8] = din[7:0];
        end
    end
endmodule

// File: rtl/ext_bus_splitter.sv
module ext_bus_splitter
    import ebs_pkg::*;
#(
    parameter int EXT_A_W      = 23,
    parameter int SETUP_CYC    = 1,
    parameter int STROBE_CYC   = 2,
    parameter int HOLD_CYC     = 1,
    parameter int REGION_TAG_W = 7,
    parameter logic [REGION_TAG_W-1:0] REGION_TAG = 7'h31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_asize,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [31:0]        req_addr,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [31:0]        req_wdata,
    input  logic [3:0]         req_be,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [31:0]        rsp_rdata,
    output logic               ext_cs_n,
    output logic               ext_oe_n,
    output logic               ext_we_n,
    output logic [EXT_A_W-1:0] ext_a,
    output logic [1:0]         ext_ba,
    output logic [1:0]         ext_be_n,
    output logic [15:0]        ext_dout,
    input  logic [15:0]        ext_din
);
    localparam int MAX_PH = (SETUP_CYC > STROBE_CYC) ?
                            ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                            ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
    localparam int CNT_W = $clog2(MAX_PH + 1);
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

    ebs_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [2:0]          left_q, left_d;
    logic [1:0]          ba_q, ba_d;
    logic [EXT_A_W-1:0]  a_q, a_d;
    logic [31:0]         wdata_q, wdata_d;
    logic [3:0]          be_q, be_d;
    logic                write_q, write_d;
    logic                wide_q, wide_d;
    logic                err_q, err_d;
    logic [31:0]         rdata_q, rdata_d;

    logic       dec_hit, dec_bad;
    logic [2:0] dec_n;
    logic [1:0] dec_ba;
    logic [15:0] lane_dout;
    logic [1:0]  lane_be_n;
    logic [31:0] lane_rdata;
    logic        active;

    ebs_decode #(
        .REGION_TAG_W(REGION_TAG_W),
        .REGION_TAG  (REGION_TAG)
    ) decode_i (
        .addr     (req_addr),
        .size     (req_size),
        .wide     (cfg_asize),
        .hit      (dec_hit),
        .bad_align(dec_bad),
        .n_acc    (dec_n),
        .ba_first (dec_ba)
    );

    ebs_lane lane_i (
        .wide     (wide_q),
        .write    (write_q),
        .ba       (ba_q),
        .wdata    (wdata_q),
        .be       (be_q),
        .din      (ext_din),
        .rdata_in (rdata_q),
        .dout     (lane_dout),
        .be_n     (lane_be_n),
        .rdata_out(lane_rdata)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        left_d  = left_q;
        ba_d    = ba_q;
        a_d     = a_q;
        wdata_d = wdata_q;
        be_d    = be_q;
        write_d = write_q;
        wide_d  = wide_q;
        err_d   = err_q;
        rdata_d = rdata_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    rdata_d = 32'h0;
                    if (!dec_hit || dec_bad) begin
                        err_d   = 1'b1;
                        state_d = ST_RESP;
                    end else begin
                        err_d   = 1'b0;
                        wide_d  = cfg_asize;
                        left_d  = dec_n;
                        ba_d    = dec_ba;
                        a_d     = req_addr[EXT_A_W+1:2];
                        wdata_d = req_wdata;
                        be_d    = req_be;
                        write_d = req_write;
                        cnt_d   = SETUP_LD;
                        state_d = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                if (cnt_q == '0) begin
                    cnt_d   = STROBE_LD;
                    state_d = ST_STROBE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt_q == '0) begin
                    if (!write_q) rdata_d = lane_rdata;
                    cnt_d   = HOLD_LD;
                    state_d = ST_HOLD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (left_q == 3'd1) begin
                    state_d = ST_RESP;
                end else begin
                    left_d  = left_q - 3'd1;
                    ba_d    = ba_q + (wide_q ? 2'd2 : 2'd1);
                    cnt_d   = SETUP_LD;
                    state_d = ST_SETUP;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            left_q  <= '0;
            ba_q    <= '0;
            a_q     <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            write_q <= 1'b0;
            wide_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            left_q  <= left_d;
            ba_q    <= ba_d;
            a_q     <= a_d;
            wdata_q <= wdata_d;
            be_q    <= be_d;
            write_q <= write_d;
            wide_q  <= wide_d;
            err_q   <= err_d;
            rdata_q <= rdata_d;
        end
    end

    // outputs
    always_comb begin
        active    = 1'b0;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        ext_oe_n  = 1'b1;
        ext_we_n  = 1'b1;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_SETUP:  active = 1'b1;
            ST_STROBE: begin
                active   = 1'b1;
                ext_oe_n = write_q;
                ext_we_n = !write_q;
            end
            ST_HOLD:   active = 1'b1;
            ST_RESP:   rsp_valid = 1'b1;
            default:   req_ready = 1'b0;
        endcase
        ext_cs_n  = !active;
        ext_a     = a_q;
        ext_ba    = active ? ba_q : 2'b00;
        ext_be_n  = active ? lane_be_n : 2'b11;
        ext_dout  = lane_dout;
        rsp_err   = rsp_valid && err_q;
        rsp_rdata = rdata_q;
    end
endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
    parameter int EXT_A_W = 23
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_asize,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic               ext_cs_n,
    input logic               ext_oe_n,
    input logic               ext_we_n,
    input logic [EXT_A_W-1:0] ext_a,
    input logic [1:0]         ext_ba
);
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_oe_n && !ext_we_n));
    assert_strobe_in_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_oe_n || !ext_we_n) |-> !ext_cs_n);
    assert_rsp_outside_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ext_cs_n);
    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_cs_n && $past(!ext_cs_n)) |-> $stable(ext_a));
    assert_ba0_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_cs_n && cfg_asize) |-> (ext_ba[0] == 1'b0));
    assert_err_in_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);
    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_cs_n || rsp_valid) |-> !req_ready);
endmodule

bind ext_bus_splitter ebs_checker #(.EXT_A_W(EXT_A_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_asize(cfg_asize),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .ext_cs_n (ext_cs_n),
    .ext_oe_n (ext_oe_n),
    .ext_we_n (ext_we_n),
    .ext_a    (ext_a),
    .ext_ba   (ext_ba)
);

// File: tb/ext_bus_splitter_tb_top.sv
module ext_bus_splitter_tb_top;
    localparam int AW = 23;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_asize = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_addr = '0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [31:0]   req_wdata = '0;
    logic [3:0]    req_be = '0;
    logic          rsp_valid, rsp_err;
    logic [31:0]   rsp_rdata;
    logic          ext_cs_n, ext_oe_n, ext_we_n;
    logic [AW-1:0] ext_a;
    logic [1:0]    ext_ba, ext_be_n;
    logic [15:0]   ext_dout, ext_din;

    int checks = 0;
    int failures = 0;

    always #5ns clk = ~clk;

    ext_bus_splitter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_asize(cfg_asize),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n),
        .ext_we_n(ext_we_n), .ext_a(ext_a), .ext_ba(ext_ba),
        .ext_be_n(ext_be_n), .ext_dout(ext_dout), .ext_din(ext_din)
    );

    // external device model: data depends on address and bank bits
    function automatic logic [15:0] dev_word(input logic [AW-1:0] a, input logic [1:0] ba);
        logic [7:0] lo;
        lo = {a[5:0], ba};
        return {8'h5A ^ lo, lo};
    endfunction
    assign ext_din = dev_word(ext_a, ext_ba);

    // passive monitor
    logic [AW-1:0] lg_a [8];
    logic [1:0]    lg_ba [8];
    logic [1:0]    lg_ben [8];
    logic [15:0]   lg_dout [8];
    int nlog = 0, ncs = 0, nstrb = 0;
    logic prev_strb = 1'b0;
    always @(negedge clk) begin
        logic strb;
        strb = !ext_oe_n || !ext_we_n;
        if (!ext_cs_n) ncs++;
        if (strb) nstrb++;
        if (strb && !prev_strb && nlog < 8) begin
            lg_a[nlog]    = ext_a;
            lg_ba[nlog]   = ext_ba;
            lg_ben[nlog]  = ext_be_n;
            lg_dout[nlog] = ext_dout;
            nlog++;
        end
        prev_strb = strb;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // issue one request, wait for response; cyc = rising edges after acceptance
    task automatic do_req(input logic [31:0] addr, input logic wr, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [3:0] be,
                          output int cyc, output logic [31:0] rd, output logic er);
        @(negedge clk);
        nlog = 0; ncs = 0; nstrb = 0;
        req_valid = 1'b1; req_addr = addr; req_write = wr;
        req_size = sz; req_wdata = wd; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!rsp_valid && cyc < 100) begin
            @(posedge clk); cyc++;
            @(negedge clk);
        end
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    task automatic check_timing(input int cyc, input int n, input string tag);
        chk(cyc == 4*n, {tag, " response cycle R7"}, cyc, 4*n);
        chk(ncs == 4*n, {tag, " cs low cycles R7"}, ncs, 4*n);
        chk(nstrb == 2*n, {tag, " strobe low cycles R7"}, nstrb, 2*n);
        chk(nlog == n, {tag, " access count R3"}, nlog, n);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "reset ready R10", req_ready, 1);
        chk({ext_cs_n, ext_oe_n, ext_we_n} == 3'b111, "reset strobes R7",
            {ext_cs_n, ext_oe_n, ext_we_n}, 3'b111);
        chk(rsp_valid == 1'b0, "reset rsp R7", rsp_valid, 0);
    endtask

    task automatic t_wide_read32;
        int c; logic [31:0] rd; logic er;
        cfg_asize = 1'b1;
        do_req(32'h6200_0010, 1'b0, 2'd2, '0, 4'hF, c, rd, er);
        check_timing(c, 2, "wide rd32");
        chk(lg_a[0] == 23'd4 && lg_a[1] == 23'd4, "wide rd32 addr R4", {lg_a[0], lg_a[1]}, {23'd4, 23'd4});
        chk(lg_ba[0] == 2'b00 && lg_ba[1] == 2'b10, "wide rd32 bank order R5", {lg_ba[0], lg_ba[1]}, 4'b0010);
        chk(rd == {dev_word(23'd4, 2'b10), dev_word(23'd4, 2'b00)}, "wide rd32 data R8",
            rd, {dev_word(23'd4, 2'b10), dev_word(23'd4, 2'b00)});
        chk(er == 1'b0, "wide rd32 no err R1", er, 0);
        chk(lg_ben[0] == 2'b00, "wide rd be_n R9", lg_ben[0], 0);
    endtask

    task automatic t_wide_read16_high;
        int c; logic [31:0] rd; logic er;
        cfg_asize = 1'b1;
        do_req(32'h6200_0106, 1'b0, 2'd1, '0, 4'hC, c, rd, er);
        check_timing(c, 1, "wide rd16");
        chk(lg_a[0] == 23'h41, "wide rd16 addr R4", lg_a[0], 23'h41);
        chk(lg_ba[0] == 2'b10, "wide rd16 bank R5", lg_ba[0], 2'b10);
        chk(rd == {dev_word(23'h41, 2'b10), 16'h0}, "wide rd16 data R8", rd, {dev_word(23'h41, 2'b10), 16'h0});
    endtask

    task automatic t_wide_write32;
        int c; logic [31:0] rd; logic er;
        cfg_asize = 1'b1;
        do_req(32'h63FF_FFFC, 1'b1, 2'd2, 32'hCAFE_1234, 4'b1011, c, rd, er);
        check_timing(c, 2, "wide wr32");
        chk(lg_a[0] == 23'h7FFFFF && lg_a[1] == 23'h7FFFFF, "wide wr32 top addr R4", lg_a[1], 23'h7FFFFF);
        chk(lg_ba[0] == 2'b00 && lg_ba[1] == 2'b10, "wide wr32 bank order R5", {lg_ba[0], lg_ba[1]}, 4'b0010);
        chk(lg_dout[0] == 16'h1234 && lg_dout[1] == 16'hCAFE, "wide wr32 lanes R9",
            {lg_dout[0], lg_dout[1]}, 32'h1234_CAFE);
        chk(lg_ben[0] == 2'b00 && lg_ben[1] == 2'b01, "wide wr32 be_n R9",
            {lg_ben[0], lg_ben[1]}, 4'b0001);
    endtask

    task automatic t_narrow_read32;
        int c; logic [31:0] rd; logic er; logic [31:0] exp;
        cfg_asize = 1'b0;
        do_req(32'h6200_0020, 1'b0, 2'd2, '0, 4'hF, c, rd, er);
        check_timing(c, 4, "narrow rd32");
        for (int i = 0; i < 4; i++) begin
            chk(lg_ba[i] == 2'(i), "narrow rd32 bank step R6", lg_ba[i], i);
            chk(lg_a[i] == 23'd8, "narrow rd32 addr R4", lg_a[i], 8);
        end
        for (int i = 0; i < 4; i++) exp[i*8 +: 8] = dev_word(23'd8, 2'(i)) & 16'h00FF;
        chk(rd == exp, "narrow rd32 data R8", rd, exp);
        chk(lg_ben[0] == 2'b10, "narrow rd be_n R9", lg_ben[0], 2'b10);
    endtask

    task automatic t_narrow_write8;
        int c; logic [31:0] rd; logic er;
        cfg_asize = 1'b0;
        do_req(32'h6200_0033, 1'b1, 2'd0, 32'hA1B2_C3D4, 4'b1000, c, rd, er);
        check_timing(c, 1, "narrow wr8");
        chk(lg_ba[0] == 2'b11, "narrow wr8 bank R6", lg_ba[0], 2'b11);
        chk(lg_a[0] == 23'hC, "narrow wr8 addr R4", lg_a[0], 23'hC);
        chk(lg_dout[0] == 16'h00A1, "narrow wr8 lane R9", lg_dout[0], 16'h00A1);
        chk(lg_ben[0] == 2'b10, "narrow wr8 be_n R9", lg_ben[0], 2'b10);
    endtask

    task automatic t_narrow_read16;
        int c; logic [31:0] rd; logic er; logic [31:0] exp;
        cfg_asize = 1'b0;
        do_req(32'h6200_0042, 1'b0, 2'd1, '0, 4'hC, c, rd, er);
        check_timing(c, 2, "narrow rd16");
        chk(lg_ba[0] == 2'b10 && lg_ba[1] == 2'b11, "narrow rd16 bank R6", {lg_ba[0], lg_ba[1]}, 4'b1011);
        exp = {dev_word(23'h10, 2'b11)[7:0], dev_word(23'h10, 2'b10)[7:0], 16'h0};
        chk(rd == exp, "narrow rd16 data R8", rd, exp);
    endtask

    task automatic t_out_of_region;
        int c; logic [31:0] rd; logic er;
        cfg_asize = 1'b1;
        do_req(32'h6400_0000, 1'b0, 2'd2, '0, 4'hF, c, rd, er);
        chk(er == 1'b1, "above region err R1", er, 1);
        chk(c == 0 && nlog == 0 && ncs == 0, "above region no access R1", {c[7:0], nlog[7:0]}, 0);
        chk(rd == 32'h0, "above region data R1", rd, 0);
        do_req(32'h61FF_FFFC, 1'b1, 2'd2, 32'hFFFF_FFFF, 4'hF, c, rd, er);
        chk(er == 1'b1 && nlog == 0 && ncs == 0, "below region err R1", {er, nlog[7:0]}, {1'b1, 8'd0});
    endtask

    task automatic t_misaligned;
        int c; logic [31:0] rd; logic er;
        cfg_asize = 1'b1;
        do_req(32'h6200_0002, 1'b0, 2'd2, '0, 4'hF, c, rd, er);
        chk(er == 1'b1 && c == 0 && nlog == 0, "word misaligned R2", {er, nlog[7:0]}, {1'b1, 8'd0});
        cfg_asize = 1'b0;
        do_req(32'h6200_0005, 1'b1, 2'd1, '0, 4'h3, c, rd, er);
        chk(er == 1'b1 && nlog == 0 && ncs == 0, "half misaligned R2", {er, nlog[7:0]}, {1'b1, 8'd0});
        do_req(32'h6200_0000, 1'b0, 2'd3, '0, 4'hF, c, rd, er);
        chk(er == 1'b1 && nlog == 0, "size code 3 R2", {er, nlog[7:0]}, {1'b1, 8'd0});
    endtask

    task automatic t_busy_ignored;
        int c; int extra;
        cfg_asize = 1'b1;
        @(negedge clk);
        nlog = 0; ncs = 0; nstrb = 0;
        req_valid = 1'b1; req_addr = 32'h6200_0080; req_write = 1'b0;
        req_size = 2'd2; req_be = 4'hF;
        @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b0, "busy ready low R10", req_ready, 0);
        req_addr = 32'h6200_0090;
        c = 0;
        while (!rsp_valid && c < 100) begin
            @(posedge clk); c++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(c == 8, "busy first response R10", c, 8);
        extra = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (rsp_valid || !ext_cs_n) extra++;
        end
        chk(extra == 0 && nlog == 2, "busy request ignored R10", {extra[7:0], nlog[7:0]}, {8'd0, 8'd2});
        chk(lg_a[0] == 23'h20, "busy keeps first addr R10", lg_a[0], 23'h20);
    endtask

    initial begin
        #2ms;
        failures++;
        checks++;
        $display("FAIL watchdog expired R7 actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wide_read32();
        t_wide_read16_high();
        t_wide_write32();
        t_narrow_read32();
        t_narrow_write8();
        t_narrow_read16();
        t_out_of_region();
        t_misaligned();
        t_busy_ignored();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule